// File: doc/BRIEF.md
# Shared-Memory Ring Channel Accessor

This block lets the host side read and write bytes through ring buffers that live in the memory of a target processor. Software on that processor uses the same buffers. Each buffer is set up as a channel. A channel holds a data base address, a local copy of the ring size mask, and local copies of both ring indices. The ring header sits just below the data base. The host owns the input (producer) index when it puts bytes and the output (consumer) index when it takes bytes. The index owned by the other side is read again from shared memory every time the block checks the ring.

Every memory access happens inside a bus ownership window. The block raises a request, waits for a grant or a denial, makes one or more byte reads or writes on the memory port, and then releases the bus. Commands are accepted one at a time from a simple valid/ready command port. Each command ends with a one-cycle response that carries a data byte, a flag and an error bit. The supported commands are initialise, empty query, full query, non-blocking get, blocking get and blocking put.

Top module: `ringacc_top`

## Requirements
- R1: Ring header layout and initialise. The size mask is at base−3, the input index at base−2 and the output index at base−1. Data slot k is at base+k. An initialise command with a nonzero base stores the base for the channel. Within one bus ownership it then reads the three header bytes in the order mask, input index, output index, and loads them as the channel's local copies.
- R2: A channel whose base is zero is disabled. On a disabled channel, an empty query returns flag 1, a full query returns flag 0, and a get, blocking get or put returns flag 1 (not available). None of these commands requests the bus.
- R3: An empty query reads the input index at base−2. It returns flag 1 exactly when that value equals the local output index.
- R4: A full query reads the output index at base−1. It returns flag 1 exactly when ((local input index + 1) AND mask) equals that value.
- R5: A non-blocking get on a non-empty ring does all of the following within one ownership: it reads the byte at base + local output index, returns that byte with flag 0, writes the advanced output index to base−1, and updates the local copy. On an empty ring it returns flag 1 and writes nothing.
- R6: A put on a non-full ring does all of the following within one ownership: it writes the data byte at base + local input index, writes the advanced input index to base−2, and updates the local copy.
- R7: An index advances as (index + 1) AND mask, so it wraps to 0 after the last slot.
- R8: A blocking get that finds the ring empty, or a blocking put that finds it full, releases the bus and polls again. Every poll uses its own acquire and release. The command completes once the condition clears.
- R9: A memory access (mem_req) is made only while the bus is requested and granted. No new access starts until the previous one has been acknowledged.
- R10: If the bus is denied (bus_deny during a request), the command ends with rsp_err = 1, and no local index or mask changes.
- R11: After reset, cmd_ready = 1 and bus_req, mem_req and rsp_valid are all 0.
- R12: Command codes on cmd_op are: 0 initialise (cmd_arg = base), 1 empty query, 2 full query, 3 get, 4 blocking get, 5 put (cmd_arg[7:0] = byte). rsp_valid is a single-cycle pulse, raised only with the bus released, and cmd_ready returns in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, taken when cmd_ready is 1 |
| cmd_op | input | 3 | Command code (see R12) |
| cmd_ch | input | CHW | Channel number |
| cmd_arg | input | AW | Base address for initialise, or data byte in the low bits for put |
| cmd_ready | output | 1 | Block is idle and can take a command |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | IW | Byte returned by a get |
| rsp_flag | output | 1 | Empty, full or not-available result |
| rsp_err | output | 1 | Bus acquire was denied |
| bus_req | output | 1 | Bus ownership request, held for the whole window |
| bus_gnt | input | 1 | Bus granted |
| bus_deny | input | 1 | Bus request refused |
| mem_req | output | 1 | One-cycle memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Target memory byte address |
| mem_wdata | output | IW | Write byte |
| mem_ack | input | 1 | Access complete, read byte valid |
| mem_rdata | input | IW | Read byte |

## Verification
Assertions check three properties on every cycle. Memory strobes appear only under a granted request, with at most one access outstanding. A disabled channel never requests the bus. Each response arrives with the bus released and is followed by an idle cycle. The index written back is also checked to stay inside the mask. Some behaviours only the bench scenarios can show: correct data ordering through the ring, wrap of both indices, initialisation from a header that already holds nonzero indices, repeated polls while a blocking get or put waits for a simulated target, and unchanged local indices after a denied acquire.

// File: rtl/ringacc_pkg.sv
package ringacc_pkg;
  typedef enum logic [2:0] {
    OP_INIT  = 3'd0,
    OP_EMPTY = 3'd1,
    OP_FULL  = 3'd2,
    OP_GET   = 3'd3,
    OP_GETW  = 3'd4,
    OP_PUT   = 3'd5
  } rop_e;

  typedef enum logic [2:0] {
    SG_MASK, SG_IN, SG_OUT, SG_PEER, SG_DRD, SG_DWR, SG_IDXW
  } step_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_DISP, FS_ACQ, FS_ACC, FS_REL, FS_DONE
  } fsm_e;
endpackage

// File: rtl/ringacc_desc.sv
module ringacc_desc #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int IW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CHW-1:0] sel,
  input  logic           base_we,
  input  logic [AW-1:0]  base_wd,
  input  logic           hdr_we,
  input  logic [IW-1:0]  mask_wd,
  input  logic [IW-1:0]  in_wd,
  input  logic [IW-1:0]  out_wd,
  input  logic           in_we,
  input  logic           out_we,
  input  logic [IW-1:0]  idx_wd,
  output logic [AW-1:0]  base_o,
  output logic [IW-1:0]  mask_o,
  output logic [IW-1:0]  in_o,
  output logic [IW-1:0]  out_o
);
  logic [AW-1:0] base_a [NCH];
  logic [IW-1:0] mask_a [NCH];
  logic [IW-1:0] in_a   [NCH];
  logic [IW-1:0] out_a  [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic          hit;
    logic [AW-1:0] b_q;
    logic [IW-1:0] m_q, i_q, o_q;
    assign hit = (sel == CHW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= '0; m_q <= '0; i_q <= '0; o_q <= '0;
      end else if (hit) begin
        if (base_we) b_q <= base_wd;
        if (hdr_we) begin
          m_q <= mask_wd; i_q <= in_wd; o_q <= out_wd;
        end
        if (in_we)  i_q <= idx_wd;
        if (out_we) o_q <= idx_wd;
      end
    end
    assign base_a[g] = b_q;
    assign mask_a[g] = m_q;
    assign in_a[g]   = i_q;
    assign out_a[g]  = o_q;
  end

  assign base_o = base_a[sel];
  assign mask_o = mask_a[sel];
  assign in_o   = in_a[sel];
  assign out_o  = out_a[sel];
endmodule

// File: rtl/ringacc_ctrl.sv
module ringacc_ctrl
  import ringacc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int IW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic [CHW-1:0] cmd_ch,
  input  logic [AW-1:0]  cmd_arg,
  output logic           cmd_ready,
  output logic           rsp_valid,
  output logic [IW-1:0]  rsp_data,
  output logic           rsp_flag,
  output logic           rsp_err,
  output logic           bus_req,
  input  logic           bus_gnt,
  input  logic           bus_deny,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [IW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [IW-1:0]  mem_rdata,
  output logic [CHW-1:0] sel,
  output logic           base_we,
  output logic [AW-1:0]  base_wd,
  output logic           hdr_we,
  output logic [IW-1:0]  mask_wd,
  output logic [IW-1:0]  in_wd,
  output logic [IW-1:0]  out_wd,
  output logic           in_we,
  output logic           out_we,
  output logic [IW-1:0]  idx_wd,
  input  logic [AW-1:0]  d_base,
  input  logic [IW-1:0]  d_mask,
  input  logic [IW-1:0]  d_in,
  input  logic [IW-1:0]  d_out
);
  function automatic logic [IW-1:0] ring_next(input logic [IW-1:0] i, input logic [IW-1:0] m);
    return (i + 1'b1) & m;
  endfunction

  function automatic logic [AW-1:0] below(input logic [AW-1:0] b, input logic [1:0] k);
    return b - AW'(k);
  endfunction

  function automatic logic [AW-1:0] slot(input logic [AW-1:0] b, input logic [IW-1:0] i);
    return b + AW'(i);
  endfunction

  fsm_e           st;
  rop_e           op_q;
  step_e          sg;
  logic [CHW-1:0] ch_q;
  logic [AW-1:0]  arg_q;
  logic           pend, poll;
  logic [IW-1:0]  t_mask, t_in;
  logic [IW-1:0]  r_data;
  logic           r_flag, r_err;

  // named events for the assertions and the step decode
  logic is_fetch, chan_on, acc_ack, empty_hit, full_hit;
  assign is_fetch  = (op_q == OP_GET) || (op_q == OP_GETW);
  assign chan_on   = (op_q == OP_INIT) ? (arg_q != '0) : (d_base != '0);
  assign acc_ack   = (st == FS_ACC) && mem_ack;
  assign empty_hit = (mem_rdata == d_out);
  assign full_hit  = (ring_next(d_in, d_mask) == mem_rdata);

  assign cmd_ready = (st == FS_IDLE);
  assign rsp_valid = (st == FS_DONE);
  assign rsp_data  = r_data;
  assign rsp_flag  = r_flag;
  assign rsp_err   = r_err;
  assign bus_req   = (st == FS_ACQ) || (st == FS_ACC);
  assign mem_req   = (st == FS_ACC) && !pend;
  assign mem_we    = (sg == SG_DWR) || (sg == SG_IDXW);

  always_comb begin
    case (sg)
      SG_MASK: mem_addr = below(d_base, 2'd3);
      SG_IN:   mem_addr = below(d_base, 2'd2);
      SG_OUT:  mem_addr = below(d_base, 2'd1);
      SG_PEER: mem_addr = (op_q == OP_EMPTY || is_fetch) ? below(d_base, 2'd2) : below(d_base, 2'd1);
      SG_DRD:  mem_addr = slot(d_base, d_out);
      SG_DWR:  mem_addr = slot(d_base, d_in);
      SG_IDXW: mem_addr = is_fetch ? below(d_base, 2'd1) : below(d_base, 2'd2);
      default: mem_addr = d_base;
    endcase
  end

  always_comb begin
    if (sg == SG_DWR)      mem_wdata = arg_q[IW-1:0];
    else if (is_fetch)     mem_wdata = ring_next(d_out, d_mask);
    else                   mem_wdata = ring_next(d_in, d_mask);
  end

  assign sel     = ch_q;
  assign base_we = (st == FS_DISP) && (op_q == OP_INIT);
  assign base_wd = arg_q;
  assign hdr_we  = acc_ack && (sg == SG_OUT);
  assign mask_wd = t_mask;
  assign in_wd   = t_in;
  assign out_wd  = mem_rdata;
  assign out_we  = acc_ack && (sg == SG_IDXW) && is_fetch;
  assign in_we   = acc_ack && (sg == SG_IDXW) && !is_fetch;
  assign idx_wd  = mem_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FS_IDLE; op_q <= OP_INIT; sg <= SG_MASK; ch_q <= '0; arg_q <= '0;
      pend <= 1'b0; poll <= 1'b0; t_mask <= '0; t_in <= '0;
      r_data <= '0; r_flag <= 1'b0; r_err <= 1'b0;
    end else begin
      case (st)
        FS_IDLE: if (cmd_valid) begin
          op_q <= rop_e'(cmd_op); ch_q <= cmd_ch; arg_q <= cmd_arg;
          r_data <= '0; r_flag <= 1'b0; r_err <= 1'b0; poll <= 1'b0;
          st <= FS_DISP;
        end
        FS_DISP: begin
          if (!chan_on) begin
            r_flag <= !(op_q == OP_INIT || op_q == OP_FULL);
            st <= FS_DONE;
          end else st <= FS_ACQ;
        end
        FS_ACQ: begin
          if (bus_deny) begin
            r_err <= 1'b1; st <= FS_DONE;
          end else if (bus_gnt) begin
            sg <= (op_q == OP_INIT) ? SG_MASK : SG_PEER;
            pend <= 1'b0; st <= FS_ACC;
          end
        end
        FS_ACC: begin
          if (!pend) pend <= 1'b1;
          if (mem_ack) begin
            pend <= 1'b0;
            case (sg)
              SG_MASK: begin t_mask <= mem_rdata; sg <= SG_IN; end
              SG_IN:   begin t_in <= mem_rdata; sg <= SG_OUT; end
              SG_PEER: begin
                if (op_q == OP_EMPTY) begin
                  r_flag <= empty_hit; st <= FS_REL;
                end else if (op_q == OP_FULL) begin
                  r_flag <= full_hit; st <= FS_REL;
                end else if (is_fetch) begin
                  if (empty_hit) begin
                    if (op_q == OP_GETW) poll <= 1'b1; else r_flag <= 1'b1;
                    st <= FS_REL;
                  end else sg <= SG_DRD;
                end else begin
                  if (full_hit) begin poll <= 1'b1; st <= FS_REL; end
                  else sg <= SG_DWR;
                end
              end
              SG_DRD:  begin r_data <= mem_rdata; sg <= SG_IDXW; end
              SG_DWR:  sg <= SG_IDXW;
              default: st <= FS_REL;
            endcase
          end
        end
        FS_REL: begin
          if (poll) begin poll <= 1'b0; st <= FS_ACQ; end
          else st <= FS_DONE;
        end
        FS_DONE: st <= FS_IDLE;
        default: st <= FS_IDLE;
      endcase
    end
  end

  // memory strobes only inside a granted ownership window
  p_mem_owned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (bus_req && bus_gnt));

  // no second strobe before the acknowledge of the first
  p_one_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> !mem_req);

  // a disabled channel never takes the bus
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (d_base != '0));

  // response only with the bus released, idle afterwards
  p_resp_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_req);
  p_resp_then_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (cmd_ready && !rsp_valid));

  // a committed index stays inside the ring
  p_index_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_we || out_we) |-> ((idx_wd & ~d_mask) == '0));
endmodule

// File: rtl/ringacc_top.sv
module ringacc_top #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int IW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic [CHW-1:0] cmd_ch,
  input  logic [AW-1:0]  cmd_arg,
  output logic           cmd_ready,
  output logic           rsp_valid,
  output logic [IW-1:0]  rsp_data,
  output logic           rsp_flag,
  output logic           rsp_err,
  output logic           bus_req,
  input  logic           bus_gnt,
  input  logic           bus_deny,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [IW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [IW-1:0]  mem_rdata
);
  logic [CHW-1:0] sel;
  logic           base_we, hdr_we, in_we, out_we;
  logic [AW-1:0]  base_wd, d_base;
  logic [IW-1:0]  mask_wd, in_wd, out_wd, idx_wd, d_mask, d_in, d_out;

  ringacc_ctrl #(.NCH(NCH), .AW(AW), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ch(cmd_ch), .cmd_arg(cmd_arg),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_flag(rsp_flag), .rsp_err(rsp_err),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_deny(bus_deny),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .sel(sel), .base_we(base_we), .base_wd(base_wd), .hdr_we(hdr_we),
    .mask_wd(mask_wd), .in_wd(in_wd), .out_wd(out_wd),
    .in_we(in_we), .out_we(out_we), .idx_wd(idx_wd),
    .d_base(d_base), .d_mask(d_mask), .d_in(d_in), .d_out(d_out)
  );

  ringacc_desc #(.NCH(NCH), .AW(AW), .IW(IW)) u_desc (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .base_we(base_we), .base_wd(base_wd), .hdr_we(hdr_we),
    .mask_wd(mask_wd), .in_wd(in_wd), .out_wd(out_wd),
    .in_we(in_we), .out_we(out_we), .idx_wd(idx_wd),
    .base_o(d_base), .mask_o(d_mask), .in_o(d_in), .out_o(d_out)
  );
endmodule

// File: tb/ringacc_top_bench.sv
module ringacc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_ch = '0;
  logic [15:0] cmd_arg = '0;
  logic        cmd_ready, rsp_valid, rsp_flag, rsp_err;
  logic [7:0]  rsp_data;
  logic        bus_req, bus_gnt, bus_deny;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic        deny_mode = 1'b0;
  logic        tgt_we = 1'b0;
  logic [9:0]  tgt_addr = '0;
  logic [7:0]  tgt_data = '0;
  logic [7:0]  mem [1024];
  logic [1:0]  gcnt;
  int          acq_cnt;
  int          nchk = 0, nfail = 0;
  logic [7:0]  r_data;
  logic        r_flag, r_err;

  always #5 clk = ~clk;

  ringacc_top u_ringacc_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ch(cmd_ch), .cmd_arg(cmd_arg), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_flag(rsp_flag), .rsp_err(rsp_err),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_deny(bus_deny),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // target memory: one-cycle acknowledge, target-side writes share the port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (tgt_we) mem[tgt_addr] <= tgt_data;
      if (mem_req) begin
        mem_ack <= 1'b1;
        mem_rdata <= mem[mem_addr[9:0]];
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      end
    end
  end

  // bus arbiter model: answer two cycles after the request rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_gnt <= 1'b0; bus_deny <= 1'b0; gcnt <= '0; acq_cnt <= 0;
    end else begin
      bus_deny <= 1'b0;
      if (!bus_req) begin
        bus_gnt <= 1'b0; gcnt <= '0;
      end else if (!bus_gnt && !bus_deny) begin
        if (gcnt == 2'd2) begin
          gcnt <= '0;
          if (deny_mode) bus_deny <= 1'b1;
          else begin bus_gnt <= 1'b1; acq_cnt <= acq_cnt + 1; end
        end else gcnt <= gcnt + 1'b1;
      end
    end
  end

  localparam int NV = 26;
  // {op[30:28], ch[27:26], arg[25:10], exp_data[9:2], exp_flag[1], exp_err[0]}
  localparam logic [30:0] VEC [NV] = '{
    {3'd0, 2'd0, 16'h0100, 8'h00, 1'b0, 1'b0},
    {3'd1, 2'd0, 16'h0000, 8'h00, 1'b1, 1'b0},
    {3'd5, 2'd0, 16'h00A1, 8'h00, 1'b0, 1'b0},
    {3'd5, 2'd0, 16'h00B2, 8'h00, 1'b0, 1'b0},
    {3'd1, 2'd0, 16'h0000, 8'h00, 1'b0, 1'b0},
    {3'd2, 2'd0, 16'h0000, 8'h00, 1'b0, 1'b0},
    {3'd3, 2'd0, 16'h0000, 8'hA1, 1'b0, 1'b0},
    {3'd3, 2'd0, 16'h0000, 8'hB2, 1'b0, 1'b0},
    {3'd3, 2'd0, 16'h0000, 8'h00, 1'b1, 1'b0},
    {3'd0, 2'd2, 16'h0000, 8'h00, 1'b0, 1'b0},
    {3'd1, 2'd2, 16'h0000, 8'h00, 1'b1, 1'b0},
    {3'd2, 2'd2, 16'h0000, 8'h00, 1'b0, 1'b0},
    {3'd3, 2'd2, 16'h0000, 8'h00, 1'b1, 1'b0},
    {3'd5, 2'd2, 16'h0055, 8'h00, 1'b1, 1'b0},
    {3'd0, 2'd1, 16'h0200, 8'h00, 1'b0, 1'b0},
    {3'd5, 2'd1, 16'h0011, 8'h00, 1'b0, 1'b0},
    {3'd5, 2'd1, 16'h0022, 8'h00, 1'b0, 1'b0},
    {3'd5, 2'd1, 16'h0033, 8'h00, 1'b0, 1'b0},
    {3'd2, 2'd1, 16'h0000, 8'h00, 1'b1, 1'b0},
    {3'd4, 2'd1, 16'h0000, 8'h11, 1'b0, 1'b0},
    {3'd2, 2'd1, 16'h0000, 8'h00, 1'b0, 1'b0},
    {3'd5, 2'd1, 16'h0044, 8'h00, 1'b0, 1'b0},
    {3'd3, 2'd1, 16'h0000, 8'h22, 1'b0, 1'b0},
    {3'd3, 2'd1, 16'h0000, 8'h33, 1'b0, 1'b0},
    {3'd3, 2'd1, 16'h0000, 8'h44, 1'b0, 1'b0},
    {3'd1, 2'd1, 16'h0000, 8'h00, 1'b1, 1'b0}
  };

  function automatic string req_of(input logic [2:0] op, input logic [1:0] ch);
    if (ch == 2'd2) return "R2";
    case (op)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tw(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    tgt_we = 1'b1; tgt_addr = a; tgt_data = d;
    @(negedge clk);
    tgt_we = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [1:0] ch, input logic [15:0] arg);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = ch; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_data = rsp_data; r_flag = rsp_flag; r_err = rsp_err;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int a0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(cmd_ready == 1'b1, "R11 cmd_ready", cmd_ready, 1);
    chk({bus_req, mem_req, rsp_valid} == 3'b000, "R11 bus/mem/rsp idle",
        {bus_req, mem_req, rsp_valid}, 0);
    rst_n = 1'b1;

    tw(10'h0FD, 8'h07); tw(10'h0FE, 8'h00); tw(10'h0FF, 8'h00);
    tw(10'h1FD, 8'h03); tw(10'h1FE, 8'h00); tw(10'h1FF, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op; logic [1:0] ch; logic [7:0] ed; logic ef, ee;
      op = VEC[i][30:28]; ch = VEC[i][27:26];
      ed = VEC[i][9:2]; ef = VEC[i][1]; ee = VEC[i][0];
      a0 = acq_cnt;
      do_cmd(op, ch, VEC[i][25:10]);
      if ((op == 3'd3 || op == 3'd4) && !ef)
        chk(r_data == ed, req_of(op, ch), r_data, ed);
      chk(r_flag == ef && r_err == ee, req_of(op, ch), {r_flag, r_err}, {ef, ee});
      if (ch == 2'd2) chk(acq_cnt == a0, "R2 no bus on disabled", acq_cnt - a0, 0);
    end

    // R12: response is one cycle, ready follows
    @(negedge clk);
    chk(cmd_ready && !rsp_valid, "R12 ready after response", {cmd_ready, rsp_valid}, 2);

    // R5/R6/R7: shared-memory contents after the table
    chk(mem[10'h0FF] == 8'h02, "R5 out index written at base-1", mem[10'h0FF], 2);
    chk(mem[10'h0FE] == 8'h02, "R6 in index written at base-2", mem[10'h0FE], 2);
    chk(mem[10'h100] == 8'hA1, "R6 data at base+in", mem[10'h100], 8'hA1);
    chk(mem[10'h1FE] == 8'h00 && mem[10'h1FF] == 8'h00, "R7 both indices wrapped",
        {mem[10'h1FE], mem[10'h1FF]}, 0);

    // R1: initialise from a header with nonzero indices
    tw(10'h2FD, 8'h0F); tw(10'h2FE, 8'h05); tw(10'h2FF, 8'h04); tw(10'h304, 8'h9C);
    do_cmd(3'd0, 2'd3, 16'h0300);
    do_cmd(3'd1, 2'd3, 16'h0000);
    chk(r_flag == 1'b0, "R1 loaded indices not empty", r_flag, 0);
    do_cmd(3'd3, 2'd3, 16'h0000);
    chk(r_data == 8'h9C && !r_flag, "R1 get at loaded out index", r_data, 8'h9C);
    chk(mem[10'h2FF] == 8'h05, "R1 advanced from loaded index", mem[10'h2FF], 5);

    // R8: blocking get waits for the target to produce
    a0 = acq_cnt;
    fork
      do_cmd(3'd4, 2'd0, 16'h0000);
      begin repeat (60) @(negedge clk); tw(10'h102, 8'h5A); tw(10'h0FE, 8'h03); end
    join
    chk(r_data == 8'h5A && !r_flag, "R8 blocking get data", r_data, 8'h5A);
    chk(acq_cnt - a0 >= 2, "R8 get polls reacquire", acq_cnt - a0, 2);

    // R8: blocking put waits for the target to consume
    do_cmd(3'd5, 2'd1, 16'h0066);
    do_cmd(3'd5, 2'd1, 16'h0077);
    do_cmd(3'd5, 2'd1, 16'h0088);
    a0 = acq_cnt;
    fork
      do_cmd(3'd5, 2'd1, 16'h0099);
      begin repeat (60) @(negedge clk); tw(10'h1FF, 8'h01); end
    join
    chk(!r_flag && mem[10'h203] == 8'h99, "R8 blocking put data", mem[10'h203], 8'h99);
    chk(mem[10'h1FE] == 8'h00, "R7 put index wrap", mem[10'h1FE], 0);
    chk(acq_cnt - a0 >= 2, "R8 put polls reacquire", acq_cnt - a0, 2);

    // R10: denied acquire leaves the local index alone
    tw(10'h103, 8'h77); tw(10'h0FE, 8'h04);
    deny_mode = 1'b1;
    do_cmd(3'd3, 2'd0, 16'h0000);
    chk(r_err == 1'b1, "R10 deny reported", r_err, 1);
    chk(mem[10'h0FF] == 8'h03, "R10 nothing written on deny", mem[10'h0FF], 3);
    deny_mode = 1'b0;
    do_cmd(3'd3, 2'd0, 16'h0000);
    chk(r_data == 8'h77 && !r_err, "R10 local out index kept", r_data, 8'h77);
    chk(mem[10'h0FF] == 8'h04, "R5 out index after get", mem[10'h0FF], 4);

    // R9: no strobe outside ownership while idle
    @(negedge clk);
    chk(!mem_req && !bus_req, "R9 idle bus quiet", {mem_req, bus_req}, 0);

    finish_run();
  end
endmodule